// File: doc/BRIEF.md
# Three-Stage Serial Clock Tick Generator

This block derives the timing ticks for a two-wire serial bus master from the system clock. Three programmable stages are chained behind each other, and a fixed decade stage follows them. The first stage is a base counter set by an 8-bit high-period value. The second stage divides by a power of two. The third stage divides by a small linear factor. One half of a serial clock period therefore lasts (thp+1)·2^ndiv·(mdiv+1)·10 system cycles, and a full period lasts twice that. As a result the serial clock frequency is sys/(2·(thp+1))/2^ndiv/(mdiv+1)/10.

The block drives two outputs. A half-period tick fires at every serial clock edge and is what a bus engine uses to move its clock line. A period tick fires once per full serial clock period, on every second half tick. Settings arrive as two plain control bytes with a write strobe. The block has no data path, so neither side has a valid/ready handshake. A write loads the settings and restarts all counters, so the period that follows is never shortened.

Top module: `scl_tick_gen`

## Requirements
- R1: After reset the settings are thp=0x18, mdiv=2, ndiv=0, both outputs are low, and the first half tick rises 750 system cycles after reset is released.
- R2: The half-period tick rises once every (thp+1)·2^ndiv·(mdiv+1)·10 system cycles.
- R3: The period tick fires together with every second half tick, starting with the second one after reset or a settings write, so its period is twice the half period.
- R4: A thp value below 5 is used as 5.
- R5: The clock-control byte carries mdiv in bits 6:3 and ndiv in bits 2:0.
- R6: A write (cfg_wr high at a clock edge) loads both bytes, clears every stage counter and the phase, forces both outputs low in the next cycle, and the first half tick follows a full half period after that edge.
- R7: Each tick lasts exactly one system clock cycle.
- R8: Changes on cfg_thp or cfg_clkctl while cfg_wr is low have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for both settings bytes |
| cfg_thp | input | 8 | High-period value for the base stage |
| cfg_clkctl | input | 7 | mdiv in bits 6:3, ndiv in bits 2:0 |
| half_tick | output | 1 | One-cycle pulse at each serial clock edge |
| scl_tick | output | 1 | One-cycle pulse once per serial clock period |

## Verification
The assertions assume that a settings write takes effect in the same edge that clears the counters, and that the shortest half period is longer than one cycle. Clamping thp guarantees the second condition. The bench writes settings only on clean strobes that last one cycle, away from the clock edge. It keeps the chosen divisors small enough that several full periods run in a short simulation. It also wiggles the settings bytes with the strobe low, to show that doing so has no effect.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int THP_W  = 8;
  localparam int NDIV_W = 3;
  localparam int MDIV_W = 4;
  localparam int CTL_W  = NDIV_W + MDIV_W;

  typedef struct packed {
    logic [THP_W-1:0]  thp;
    logic [MDIV_W-1:0] mdiv;
    logic [NDIV_W-1:0] ndiv;
  } div_cfg_t;
endpackage

// File: rtl/scl_div_cfg.sv
module scl_div_cfg
  import scl_div_pkg::*;
#(
  parameter int THP_MIN  = 5,
  parameter int THP_RST  = 8'h18,
  parameter int MDIV_RST = 2,
  parameter int NDIV_RST = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [THP_W-1:0] thp_in,
  input  logic [CTL_W-1:0] ctl_in,
  output div_cfg_t         cfg
);
  logic [THP_W-1:0] thp_clamped;

  // R4: undersized high-period values are raised to the minimum
  always_comb begin
    thp_clamped = thp_in;
    if (thp_in < THP_W'(THP_MIN)) thp_clamped = THP_W'(THP_MIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.thp  <= THP_W'(THP_RST);
      cfg.mdiv <= MDIV_W'(MDIV_RST);
      cfg.ndiv <= NDIV_W'(NDIV_RST);
    end else if (wr) begin
      cfg.thp  <= thp_clamped;
      // R5: linear factor in the upper field, power-of-two exponent in the lower
      cfg.mdiv <= ctl_in[CTL_W-1:NDIV_W];
      cfg.ndiv <= ctl_in[NDIV_W-1:0];
    end
  end

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg));
endmodule

// File: rtl/scl_div_stage.sv
module scl_div_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = en && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en)     cnt <= wrap ? '0 : cnt + 1'b1;
  end

  // R6: a cleared counter never runs past its limit, so no period is cut short
  assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
endmodule

// File: rtl/scl_div_out.sv
module scl_div_out (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic half_evt,
  output logic half_tick,
  output logic scl_tick
);
  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 1'b0;
      half_tick <= 1'b0;
      scl_tick  <= 1'b0;
    end else if (clr) begin
      phase     <= 1'b0;
      half_tick <= 1'b0;
      scl_tick  <= 1'b0;
    end else begin
      half_tick <= half_evt;
      scl_tick  <= half_evt && phase;
      if (half_evt) phase <= ~phase;
    end
  end

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> !half_tick);
  assert_scl_on_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_tick |-> half_tick);
  assert_clear_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!half_tick && !scl_tick));
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
  import scl_div_pkg::*;
#(
  parameter int FIXED_DIV = 10,
  parameter int THP_MIN   = 5,
  parameter int THP_RST   = 8'h18,
  parameter int MDIV_RST  = 2,
  parameter int NDIV_RST  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [THP_W-1:0] cfg_thp,
  input  logic [CTL_W-1:0] cfg_clkctl,
  output logic             half_tick,
  output logic             scl_tick
);
  localparam int POW_W = (1 << NDIV_W) - 1;
  localparam int DEC_W = $clog2(FIXED_DIV);

  div_cfg_t         cfg;
  logic [POW_W-1:0] pow_limit;
  logic             wrap_base, wrap_pow, wrap_lin, wrap_dec;

  scl_div_cfg #(
    .THP_MIN(THP_MIN), .THP_RST(THP_RST), .MDIV_RST(MDIV_RST), .NDIV_RST(NDIV_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
    .thp_in(cfg_thp), .ctl_in(cfg_clkctl), .cfg(cfg)
  );

  // 2^ndiv - 1 as a thermometer code
  always_comb begin
    for (int i = 0; i < POW_W; i++) pow_limit[i] = (i < int'(cfg.ndiv));
  end

  scl_div_stage #(.W(THP_W)) u_base (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .en(1'b1),
    .limit(cfg.thp), .wrap(wrap_base)
  );

  scl_div_stage #(.W(POW_W)) u_pow (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .en(wrap_base),
    .limit(pow_limit), .wrap(wrap_pow)
  );

  scl_div_stage #(.W(MDIV_W)) u_lin (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .en(wrap_pow),
    .limit(cfg.mdiv), .wrap(wrap_lin)
  );

  scl_div_stage #(.W(DEC_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .en(wrap_lin),
    .limit(DEC_W'(FIXED_DIV - 1)), .wrap(wrap_dec)
  );

  scl_div_out u_out (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .half_evt(wrap_dec),
    .half_tick(half_tick), .scl_tick(scl_tick)
  );
endmodule

// File: tb/scl_tick_gen_tb_top.sv
module scl_tick_gen_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_thp = 8'h0;
  logic [6:0] cfg_clkctl = 7'h0;
  logic       half_tick, scl_tick;

  int    checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_thp = 24, m_mdiv = 2, m_ndiv = 0;
  int m_n = 0;
  bit m_half = 0, m_scl = 0, m_phase = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_thp(cfg_thp),
    .cfg_clkctl(cfg_clkctl), .half_tick(half_tick), .scl_tick(scl_tick)
  );

  function automatic int half_len();
    return (m_thp + 1) * (1 << m_ndiv) * (m_mdiv + 1) * 10;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_thp = 24; m_mdiv = 2; m_ndiv = 0;
      m_n = 0; m_half = 0; m_scl = 0; m_phase = 0;
    end else if (cfg_wr) begin
      m_thp  = (int'(cfg_thp) < 5) ? 5 : int'(cfg_thp);
      m_mdiv = int'(cfg_clkctl[6:3]);
      m_ndiv = int'(cfg_clkctl[2:0]);
      m_n = 0; m_half = 0; m_scl = 0; m_phase = 0;
    end else begin
      m_n++;
      m_half = 0; m_scl = 0;
      if (m_n == half_len()) begin
        m_n = 0; m_half = 1; m_scl = m_phase; m_phase = !m_phase;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // compared on every clock, away from the active edge (R2, R3, R7)
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check({cur_req, " half_tick"}, int'(half_tick), int'(m_half));
      check({cur_req, " scl_tick"}, int'(scl_tick), int'(m_scl));
    end
  end

  task automatic write_cfg(input logic [7:0] t, input logic [6:0] c);
    @(negedge clk);
    cfg_thp = t; cfg_clkctl = c; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic expect_gap(input string req, input int exp);
    int n = 0;
    while (!half_tick && n < exp + 50) begin
      @(negedge clk);
      n++;
    end
    check({req, " half period length"}, n, exp);
    @(negedge clk);
    check("R7 tick one cycle wide", int'(half_tick), 0);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    check("R1 half_tick in reset", int'(half_tick), 0);
    check("R1 scl_tick in reset", int'(scl_tick), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    expect_gap("R1", 750);
    cur_req = "R3";
    run(3200);

    cur_req = "R2";
    write_cfg(8'd5, 7'h00);
    expect_gap("R2", 60);
    run(300);

    cur_req = "R4";
    write_cfg(8'd2, 7'h00);
    expect_gap("R4", 60);
    run(300);

    cur_req = "R5";
    write_cfg(8'd6, {4'd1, 3'd3});
    expect_gap("R5", 1120);
    run(2400);
    write_cfg(8'd9, {4'd4, 3'd1});
    expect_gap("R5", 1000);
    run(2100);

    cur_req = "R6";
    write_cfg(8'd5, 7'h00);
    run(30);
    write_cfg(8'd5, 7'h00);
    expect_gap("R6", 60);
    run(95);
    write_cfg(8'd5, 7'h00);
    check("R6 outputs low after write", int'(half_tick | scl_tick), 0);
    expect_gap("R6", 60);
    run(200);

    cur_req = "R8";
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cfg_thp = 8'(k * 7 + 1);
      cfg_clkctl = 7'(k * 13);
    end
    run(300);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule